// File: doc/BRIEF.md
# Register-to-Register Move Unit

This unit executes the 8-bit register move group of a small 8-bit processor. It holds the working register file: B, C, D, E, H, L and A, plus one index that stands for a memory operand addressed through the H/L pair and has no storage. Each cycle it decodes the presented opcode. For a move in the group, it reads the source register, drives the destination index and the data on its write outputs, and commits the write at the next rising clock edge. The opcode's upper field picks the destination and its lower field picks the source.

One code point inside the group is the halt instruction. It is reported and never writes. Moves that name the memory operand raise a memory request and leave the register file alone. Moves from a register to itself are no-ops. Other execution groups load the register file through a side write port, and a debug read port exposes any register. The unit has no flag state, so a move can never change a flag.

Top module: `regmove_unit`

## Requirements
- R1: An opcode is in the move group exactly when `op_valid` is high and opcode bits [7:6] equal 2'b01. Outside the group `in_group`, `wr_en`, `is_halt` and `mem_req` are low and `cycles` is 0.
- R2: Opcode bits [5:3] give the destination index and bits [2:0] give the source index. Index order is 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory operand, 7=A. `wr_idx` shows the destination and `wr_data` shows the current value of the source.
- R3: Opcode 0x76 with `op_valid` raises `is_halt`, keeps `wr_en` and `mem_req` low, and leaves every register unchanged.
- R4: Any other group opcode whose source or destination index is 6 raises `mem_req`, keeps `wr_en` low, and changes no register.
- R5: A group opcode whose source equals its destination (neither index 6) keeps `wr_en` low and changes no register.
- R6: Any other group opcode raises `wr_en`. At the next rising edge the destination register takes the source value, and every other register, including the source, keeps its value.
- R7: `cycles` reports 1 for register moves, self-copies and halt, and 2 for memory-operand forms.
- R8: A synchronous active-high reset clears all registers to zero. Index 6 always reads zero, and writes to it are dropped.
- R9: The side port (`ext_wr_en`, `ext_wr_idx`, `ext_wr_data`) writes one register at the rising edge. When a move writes in the same cycle, the side write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode presented this cycle |
| opcode | input | 8 | Instruction byte |
| ext_wr_en | input | 1 | Side write enable from other groups |
| ext_wr_idx | input | 3 | Side write register index |
| ext_wr_data | input | 8 | Side write data |
| obs_idx | input | 3 | Debug read index |
| obs_data | output | 8 | Debug read data (combinational) |
| wr_en | output | 1 | Move write in this cycle |
| wr_idx | output | 3 | Move destination index |
| wr_data | output | 8 | Move data (source value) |
| in_group | output | 1 | Opcode belongs to the move group |
| is_halt | output | 1 | Halt opcode seen |
| mem_req | output | 1 | Memory operand form, no register write |
| cycles | output | 2 | Machine cycles for the instruction |

## Verification
The bench preloads distinct random values so that every move is visible. It then issues random opcodes, mostly inside the group. A copy from the wrong column, a write into the wrong row, or a disturbed source register all show up when the bench sweeps the whole register file after each edge. Directed cases cover 0x76, every diagonal self-copy, memory forms with index 6 on either side, and opcodes just outside the group (0x3F, 0x80). A side write issued in the same cycle as a move tells the write priority apart from a merge of the two writes.

// File: rtl/regmove_pkg.sv
package regmove_pkg;

    localparam int DATA_W   = 8;
    localparam int IDX_W    = 3;
    localparam int NREG     = 1 << IDX_W;
    localparam int CYC_W    = 2;
    localparam logic [IDX_W-1:0] MEM_SLOT = 3'd6;
    localparam logic [7:0]       HALT_OP  = 8'h76;
    localparam logic [1:0]       GROUP_HI = 2'b01;

    typedef enum logic [IDX_W-1:0] {
        SEL_B = 3'd0, SEL_C = 3'd1, SEL_D = 3'd2, SEL_E = 3'd3,
        SEL_H = 3'd4, SEL_L = 3'd5, SEL_M = 3'd6, SEL_A = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic             in_group;
        logic             halt;
        logic             mem_req;
        logic             self_copy;
        logic             wr_en;
        reg_sel_e         dst;
        reg_sel_e         src;
        logic [CYC_W-1:0] cycles;
    } move_dec_t;

    function automatic move_dec_t decode_move(input logic valid, input logic [7:0] op);
        move_dec_t d;
        d.in_group  = valid && (op[7:6] == GROUP_HI);
        d.dst       = reg_sel_e'(op[5:3]);
        d.src       = reg_sel_e'(op[2:0]);
        d.halt      = d.in_group && (op == HALT_OP);
        d.mem_req   = d.in_group && !d.halt &&
                      ((op[5:3] == MEM_SLOT) || (op[2:0] == MEM_SLOT));
        d.self_copy = d.in_group && !d.halt && !d.mem_req && (op[5:3] == op[2:0]);
        d.wr_en     = d.in_group && !d.halt && !d.mem_req && !d.self_copy;
        if (!d.in_group)    d.cycles = 2'd0;
        else if (d.mem_req) d.cycles = 2'd2;
        else                d.cycles = 2'd1;
        return d;
    endfunction

endpackage

// File: rtl/move_decoder.sv
module move_decoder
    import regmove_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  logic [7:0] opcode,
    output move_dec_t  dec
);

    always_comb dec = decode_move(op_valid, opcode);

    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode == HALT_OP) |-> (dec.halt && !dec.wr_en && !dec.mem_req)); // R3
    AST_MEM_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        dec.mem_req |-> (!dec.wr_en && dec.cycles == 2'd2)); // R4
    AST_SELF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (dec.in_group && dec.dst == dec.src) |-> !dec.wr_en); // R5
    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dec.in_group |-> (!dec.wr_en && !dec.halt && !dec.mem_req && dec.cycles == 2'd0)); // R1
    AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dec.wr_en, dec.halt, dec.mem_req, dec.self_copy})); // R6

endmodule

// File: rtl/move_regfile.sv
module move_regfile
    import regmove_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mv_en,
    input  logic [IDX_W-1:0]  mv_idx,
    input  logic [DATA_W-1:0] mv_data,
    input  logic              ext_en,
    input  logic [IDX_W-1:0]  ext_idx,
    input  logic [DATA_W-1:0] ext_data,
    input  logic [IDX_W-1:0]  src_idx,
    output logic [DATA_W-1:0] src_data,
    input  logic [IDX_W-1:0]  obs_idx,
    output logic [DATA_W-1:0] obs_data
);

    logic [DATA_W-1:0] store [NREG];
    logic              w_en;
    logic [IDX_W-1:0]  w_idx;
    logic [DATA_W-1:0] w_data;

    always_comb begin
        w_en   = mv_en || ext_en;
        w_idx  = mv_en ? mv_idx  : ext_idx;
        w_data = mv_en ? mv_data : ext_data;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (g == int'(MEM_SLOT)) begin : g_mem
            assign store[g] = '0;
        end else begin : g_reg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)                                  q <= '0;
                else if (w_en && w_idx == IDX_W'(g))      q <= w_data;
            end
            assign store[g] = q;
        end
    end

    assign src_data = store[src_idx];
    assign obs_data = store[obs_idx];

    AST_MOVE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (mv_en && mv_idx != MEM_SLOT) |=> store[$past(mv_idx)] == $past(mv_data)); // R6
    AST_SRC_KEPT: assert property (@(posedge clk) disable iff (rst)
        (mv_en && mv_idx != src_idx) |=> store[$past(src_idx)] == $past(src_data)); // R6
    AST_MEM_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        store[MEM_SLOT] == '0); // R8

endmodule

// File: rtl/regmove_unit.sv
module regmove_unit
    import regmove_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [7:0]  opcode,
    input  logic        ext_wr_en,
    input  logic [2:0]  ext_wr_idx,
    input  logic [7:0]  ext_wr_data,
    input  logic [2:0]  obs_idx,
    output logic [7:0]  obs_data,
    output logic        wr_en,
    output logic [2:0]  wr_idx,
    output logic [7:0]  wr_data,
    output logic        in_group,
    output logic        is_halt,
    output logic        mem_req,
    output logic [1:0]  cycles
);

    move_dec_t         dec;
    logic [DATA_W-1:0] src_val;

    move_decoder u_dec (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .opcode   (opcode),
        .dec      (dec)
    );

    move_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .mv_en    (dec.wr_en),
        .mv_idx   (dec.dst),
        .mv_data  (src_val),
        .ext_en   (ext_wr_en),
        .ext_idx  (ext_wr_idx),
        .ext_data (ext_wr_data),
        .src_idx  (dec.src),
        .src_data (src_val),
        .obs_idx  (obs_idx),
        .obs_data (obs_data)
    );

    assign wr_en    = dec.wr_en;
    assign wr_idx   = dec.dst;
    assign wr_data  = src_val;
    assign in_group = dec.in_group;
    assign is_halt  = dec.halt;
    assign mem_req  = dec.mem_req;
    assign cycles   = dec.cycles;

    AST_HALT_STABLE: assert property (@(posedge clk) disable iff (rst)
        is_halt |=> $stable(obs_data) || $past(obs_idx) != obs_idx || $past(ext_wr_en)); // R3

endmodule

// File: tb/regmove_unit_test.sv
module regmove_unit_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [7:0] opcode;
    logic       ext_wr_en;
    logic [2:0] ext_wr_idx;
    logic [7:0] ext_wr_data;
    logic [2:0] obs_idx;
    logic [7:0] obs_data;
    logic       wr_en;
    logic [2:0] wr_idx;
    logic [7:0] wr_data;
    logic       in_group;
    logic       is_halt;
    logic       mem_req;
    logic [1:0] cycles;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    regmove_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
        .ext_wr_en(ext_wr_en), .ext_wr_idx(ext_wr_idx), .ext_wr_data(ext_wr_data),
        .obs_idx(obs_idx), .obs_data(obs_data), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .in_group(in_group), .is_halt(is_halt),
        .mem_req(mem_req), .cycles(cycles)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_group(input logic v, input logic [7:0] op);
        return v && op[7:6] == 2'b01;
    endfunction
    function automatic bit exp_halt(input logic v, input logic [7:0] op);
        return exp_group(v, op) && op == 8'h76;
    endfunction
    function automatic bit exp_mem(input logic v, input logic [7:0] op);
        return exp_group(v, op) && !exp_halt(v, op) && (op[5:3] == 3'd6 || op[2:0] == 3'd6);
    endfunction
    function automatic bit exp_wr(input logic v, input logic [7:0] op);
        return exp_group(v, op) && !exp_halt(v, op) && !exp_mem(v, op) && op[5:3] != op[2:0];
    endfunction
    function automatic int exp_cyc(input logic v, input logic [7:0] op);
        if (!exp_group(v, op)) return 0;
        return exp_mem(v, op) ? 2 : 1;
    endfunction

    task automatic sweep(input string req);
        for (int i = 0; i < 8; i++) begin
            obs_idx = 3'(i);
            #1;
            check(req, $sformatf("reg%0d", i), int'(obs_data), int'(model[i]));
        end
    endtask

    task automatic step(input logic v, input logic [7:0] op, input logic xe,
                        input logic [2:0] xi, input logic [7:0] xd, input string req);
        @(negedge clk);
        op_valid = v; opcode = op; ext_wr_en = xe; ext_wr_idx = xi; ext_wr_data = xd;
        #1;
        check("R1", "in_group", int'(in_group), int'(exp_group(v, op)));
        check("R3", "is_halt", int'(is_halt), int'(exp_halt(v, op)));
        check("R4", "mem_req", int'(mem_req), int'(exp_mem(v, op)));
        check(req, "wr_en", int'(wr_en), int'(exp_wr(v, op)));
        check("R7", "cycles", int'(cycles), exp_cyc(v, op));
        if (exp_wr(v, op)) begin
            check("R2", "wr_idx", int'(wr_idx), int'(op[5:3]));
            check("R2", "wr_data", int'(wr_data), int'(model[op[2:0]]));
        end
        @(posedge clk);
        if (exp_wr(v, op)) model[op[5:3]] = model[op[2:0]];
        else if (xe && xi != 3'd6) model[xi] = xd;
        @(negedge clk);
        op_valid = 1'b0; ext_wr_en = 1'b0;
        sweep(req);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; op_valid = 1'b0; opcode = 8'h00;
        ext_wr_en = 1'b0; ext_wr_idx = 3'd0; ext_wr_data = 8'h00; obs_idx = 3'd0;
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        sweep("R8");
        // R9: preload distinct values through the side port; index 6 dropped (R8)
        for (int i = 0; i < 8; i++)
            step(1'b0, 8'h00, 1'b1, 3'(i), 8'(8'h11 * (i + 1)), "R9");
        // R3: halt
        step(1'b1, 8'h76, 1'b0, 3'd0, 8'h00, "R3");
        // R5: every self-copy
        for (int i = 0; i < 8; i++)
            if (i != 6) step(1'b1, {2'b01, 3'(i), 3'(i)}, 1'b0, 3'd0, 8'h00, "R5");
        // R4: memory forms both sides
        step(1'b1, 8'h46, 1'b0, 3'd0, 8'h00, "R4");
        step(1'b1, 8'h77, 1'b0, 3'd0, 8'h00, "R4");
        // R1: just outside the group, and invalid inside
        step(1'b1, 8'h3F, 1'b0, 3'd0, 8'h00, "R1");
        step(1'b1, 8'h80, 1'b0, 3'd0, 8'h00, "R1");
        step(1'b0, 8'h41, 1'b0, 3'd0, 8'h00, "R1");
        // R6: C into B, then A into L
        step(1'b1, 8'h41, 1'b0, 3'd0, 8'h00, "R6");
        step(1'b1, 8'h6F, 1'b0, 3'd0, 8'h00, "R6");
        // R9: side write colliding with a move is dropped
        step(1'b1, 8'h7A, 1'b1, 3'd7, 8'hEE, "R9");
        step(1'b1, 8'h50, 1'b1, 3'd1, 8'h5A, "R9");
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [7:0] op;
            logic       v;
            v  = ($urandom % 8) != 0;
            op = ($urandom % 4 != 0) ? {2'b01, 6'($urandom)} : 8'($urandom);
            if ($urandom % 3 == 0)
                step(v, op, 1'b1, 3'($urandom), 8'($urandom), "R6");
            else
                step(v, op, 1'b0, 3'd0, 8'h00, "R6");
        end
        // R8: reset clears everything
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        @(negedge clk) rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        sweep("R8");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule